// File: doc/BRIEF.md
# Paged Multichannel Register File

This block is the control and status space of a design that repeats one channel's processing N times. Each channel owns a fixed-size address page. In that page sit a writable trigger threshold and a read-only event counter, and both sit at the same offset in every page. One common hysteresis register follows the last page and drives every channel at once. The block decodes a plain single-cycle read/write bus. It presents each channel's threshold and the shared hysteresis as steady outputs, and it counts the trigger pulses each channel sends back.

The bus has no streaming data path, so it stays plain control and carries no back-pressure. A read request is always accepted, and its data returns exactly one cycle later with a valid strobe. A write takes effect at the clock edge where it is presented. The page size is a power of two, set by `PAGE_LG2`. Channel i's page starts at i·2^PAGE_LG2, and the shared register sits at N·2^PAGE_LG2.

Top module: `chan_page_regs`

## Requirements
- R1: Channel i's threshold is at address i·2^PAGE_LG2+THR_OFS, its counter at i·2^PAGE_LG2+CNT_OFS, and the shared hysteresis register at N·2^PAGE_LG2 (defaults: PAGE_LG2=11, THR_OFS=1031, CNT_OFS=1032, N=2, so the shared register is at 4096).
- R2: A write to channel i's threshold address stores wdata[THR_W-1:0]. The stored value appears on `thr_out[i*THR_W +: THR_W]` in the cycle after the write. All thresholds reset to 0.
- R3: A write to the shared address stores wdata[HYS_W-1:0] and drives it on `hyst_out` from the next cycle. It resets to 0.
- R4: `bus_rvalid` is high exactly in the cycle after `bus_rd` is high. `bus_rdata` then holds the zero-extended register value as it stood at the request edge. A write to the same address in the same cycle is therefore not yet visible in that read.
- R5: A read of any address not named in R1 returns 0 with `bus_rvalid` high. `bus_rdata` is 0 whenever `bus_rvalid` is low.
- R6: Writes to unmapped addresses or to counter addresses change no threshold, no hysteresis value and no counter.
- R7: Each cycle with `trig_in[i]` high raises channel i's counter by one. All counters reset to 0.
- R8: A counter at its all-ones value stays there when further pulses arrive.
- R9: A pulse in the same cycle as a read of that channel's counter is counted. The read returns the value before the pulse, and the next read shows it.
- R10: A pulse on one channel leaves every other channel's counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Word address (AW = clog2(N·2^PAGE_LG2+1)) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| trig_in | input | N | One trigger pulse bit per channel |
| thr_out | output | N·THR_W | Per-channel thresholds, channel i in slice i |
| hyst_out | output | HYS_W | Shared hysteresis value |

## Verification
The bench builds the block with N=3, PAGE_LG2=4, THR_OFS=7, CNT_OFS=8 and a 4-bit counter. In that configuration the whole 64-word address space, including the unused words above the shared register at 48, is swept for both writes and reads. A 4-bit counter brings saturation within reach after a handful of pulses. Three channels make a non-power-of-two page count, which exercises the decode of partial page indices, and they allow checks that neighbouring channels are isolated on both sides.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_THR,
    SEL_CNT,
    SEL_HYS
  } rd_sel_e;
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
  import cpr_pkg::*;
#(
  parameter int N        = 2,
  parameter int PAGE_LG2 = 11,
  parameter int THR_OFS  = 1031,
  parameter int CNT_OFS  = 1032,
  parameter int AW       = 13,
  parameter int CH_W     = 1
) (
  input  logic [AW-1:0]   addr,
  output rd_sel_e         sel,
  output logic [CH_W-1:0] ch
);
  localparam int PG_W = AW - PAGE_LG2;
  localparam logic [AW-1:0]       SHARED_A = AW'(N << PAGE_LG2);
  localparam logic [PAGE_LG2-1:0] THR_L    = PAGE_LG2'(THR_OFS);
  localparam logic [PAGE_LG2-1:0] CNT_L    = PAGE_LG2'(CNT_OFS);
  localparam logic [PG_W-1:0]     N_L      = PG_W'(N);

  logic [PG_W-1:0]     page;
  logic [PAGE_LG2-1:0] ofs;

  assign page = addr[AW-1:PAGE_LG2];
  assign ofs  = addr[PAGE_LG2-1:0];

  always_comb begin
    sel = SEL_NONE;
    ch  = '0;
    if (addr == SHARED_A) begin
      sel = SEL_HYS;
    end else if (page < N_L) begin
      ch = page[CH_W-1:0];
      if (ofs == THR_L)      sel = SEL_THR;
      else if (ofs == CNT_L) sel = SEL_CNT;
    end
  end
endmodule

// File: rtl/cpr_counter.sv
module cpr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (trig && q != '1)  q <= q + 1'b1;
  end
endmodule

// File: rtl/chan_page_regs.sv
module chan_page_regs
  import cpr_pkg::*;
#(
  parameter int N        = 2,
  parameter int PAGE_LG2 = 11,
  parameter int THR_OFS  = 1031,
  parameter int CNT_OFS  = 1032,
  parameter int THR_W    = 16,
  parameter int CNT_W    = 32,
  parameter int HYS_W    = 16,
  parameter int DATA_W   = 32,
  parameter int AW       = $clog2((N << PAGE_LG2) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  input  logic [N-1:0]         trig_in,
  output logic [N*THR_W-1:0]   thr_out,
  output logic [HYS_W-1:0]     hyst_out
);
  localparam int CH_W = (N > 1) ? $clog2(N) : 1;

  rd_sel_e          sel;
  logic [CH_W-1:0]  ch;
  logic [THR_W-1:0] thr_q [N];
  logic [CNT_W-1:0] cnt_q [N];
  logic [N*CNT_W-1:0] cnt_flat;
  logic [HYS_W-1:0] hyst_q;
  logic [DATA_W-1:0] rd_mux;

  cpr_decode #(
    .N(N), .PAGE_LG2(PAGE_LG2), .THR_OFS(THR_OFS), .CNT_OFS(CNT_OFS),
    .AW(AW), .CH_W(CH_W)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel),
    .ch  (ch)
  );

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr_q[i] <= '0;
      else if (bus_wr && sel == SEL_THR && ch == CH_W'(i))
        thr_q[i] <= bus_wdata[THR_W-1:0];
    end

    cpr_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trig_in[i]),
      .q    (cnt_q[i])
    );

    assign thr_out[i*THR_W +: THR_W]   = thr_q[i];
    assign cnt_flat[i*CNT_W +: CNT_W]  = cnt_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        hyst_q <= '0;
    else if (bus_wr && sel == SEL_HYS) hyst_q <= bus_wdata[HYS_W-1:0];
  end
  assign hyst_out = hyst_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_THR: rd_mux = DATA_W'(thr_q[ch]);
      SEL_CNT: rd_mux = DATA_W'(cnt_q[ch]);
      SEL_HYS: rd_mux = DATA_W'(hyst_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cpr_chk.sv
module cpr_chk #(
  parameter int N      = 2,
  parameter int THR_W  = 16,
  parameter int CNT_W  = 32,
  parameter int HYS_W  = 16,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic [N-1:0]       trig_in,
  input logic [N*THR_W-1:0] thr_out,
  input logic [HYS_W-1:0]   hyst_out,
  input logic [N*CNT_W-1:0] cnt_flat
);
  // R4
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R4
  rvalid_only_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R5
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == '0);
  // R2
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(thr_out));
  // R3
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(hyst_out));

  for (genvar i = 0; i < N; i++) begin : g_c
    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in[i] && cnt_flat[i*CNT_W +: CNT_W] != '1)
        |=> cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1);
    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[i*CNT_W +: CNT_W] == '1 |=> cnt_flat[i*CNT_W +: CNT_W] == '1);
    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_in[i] |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
  end
endmodule

bind chan_page_regs cpr_chk #(
  .N(N), .THR_W(THR_W), .CNT_W(CNT_W), .HYS_W(HYS_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .trig_in   (trig_in),
  .thr_out   (thr_out),
  .hyst_out  (hyst_out),
  .cnt_flat  (cnt_flat)
);

// File: tb/chan_page_regs_test.sv
`timescale 1ns/1ps
module chan_page_regs_test;
  localparam int N = 3, PL = 4, TOFS = 7, COFS = 8;
  localparam int TW = 16, CW = 4, HW = 16, DW = 32, AW = 6;
  localparam int SHARED = N << PL;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_rvalid;
  logic [N-1:0] trig_in = '0;
  logic [N*TW-1:0] thr_out;
  logic [HW-1:0] hyst_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [TW-1:0] m_thr [N];
  logic [HW-1:0] m_hys;
  int m_cnt [N];

  always #2 clk = ~clk;

  chan_page_regs #(
    .N(N), .PAGE_LG2(PL), .THR_OFS(TOFS), .CNT_OFS(COFS),
    .THR_W(TW), .CNT_W(CW), .HYS_W(HW), .DATA_W(DW)
  ) uut (.*);

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(int a);
    if (a == SHARED) return DW'(m_hys);
    if (a / 16 < N) begin
      if (a % 16 == TOFS) return DW'(m_thr[a/16]);
      if (a % 16 == COFS) return DW'(m_cnt[a/16]);
    end
    return '0;
  endfunction

  task automatic do_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a == SHARED) m_hys = d[HW-1:0];
    else if (a / 16 < N && a % 16 == TOFS) m_thr[a/16] = d[TW-1:0];
  endtask

  task automatic do_read(int a, logic [N-1:0] tr, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1; trig_in = tr;
    @(negedge clk);
    bus_rd = 0; trig_in = '0;
    d = bus_rdata;
    check("R4 rvalid", DW'(bus_rvalid), 1);
    for (int i = 0; i < N; i++)
      if (tr[i] && m_cnt[i] < 15) m_cnt[i]++;
  endtask

  task automatic pulse(logic [N-1:0] tr);
    @(negedge clk);
    trig_in = tr;
    @(negedge clk);
    trig_in = '0;
    for (int i = 0; i < N; i++)
      if (tr[i] && m_cnt[i] < 15) m_cnt[i]++;
  endtask

  task automatic check_outs(string req);
    for (int i = 0; i < N; i++)
      check(req, DW'(thr_out[i*TW +: TW]), DW'(m_thr[i]));
    check(req, DW'(hyst_out), DW'(m_hys));
  endtask

  task automatic check_counters(string req);
    logic [DW-1:0] d;
    for (int i = 0; i < N; i++) begin
      do_read(i*16 + COFS, '0, d);
      check(req, d, DW'(m_cnt[i]));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    for (int i = 0; i < N; i++) begin m_thr[i] = '0; m_cnt[i] = 0; end
    m_hys = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 R3 R5: reset state
    check_outs("R2/R3 reset");
    check("R5 idle rvalid", DW'(bus_rvalid), 0);
    check("R5 idle rdata", bus_rdata, 0);
    check_counters("R7 reset");

    // R1 R2 R3 R6: write every address, outputs follow model
    for (int a = 0; a < 64; a++) begin
      do_write(a, 32'hC3000000 | DW'(a * 32'h0101 + 3));
      check_outs("R1/R2/R3/R6 write sweep");
      check("R5 rdata idle", bus_rdata, 0);
    end
    check_counters("R6 counters after writes");

    // R1 R4 R5: read every address
    for (int a = 0; a < 64; a++) begin
      do_read(a, '0, d);
      check("R1/R5 read sweep", d, exp_read(a));
    end

    // R4: read and write same cycle returns old value
    @(negedge clk);
    bus_addr = AW'(16 + TOFS); bus_rd = 1; bus_wr = 1; bus_wdata = 32'h0000BEEF;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    check("R4 read-before-write", bus_rdata, DW'(m_thr[1]));
    m_thr[1] = 16'hBEEF;
    do_read(16 + TOFS, '0, d);
    check("R4 new value", d, 32'h0000BEEF);

    // R7 R10: counting patterns
    for (int k = 0; k < 7; k++) begin
      pulse(N'(k + 1));
      check_counters("R7/R10 count pattern");
    end

    // R9: pulse during read of own counter
    do_read(16 + COFS, 3'b010, d);
    check("R9 pre-increment value", d, DW'(m_cnt[1] - 1));
    do_read(16 + COFS, '0, d);
    check("R9 pulse kept", d, DW'(m_cnt[1]));

    // R8 R10: saturate channel 0
    for (int k = 0; k < 20; k++) pulse(3'b001);
    check_counters("R8/R10 saturation");
    check("R8 all ones", DW'(m_cnt[0]), 15);

    // R6: writes to counter and unmapped addresses after counting
    do_write(COFS, 32'h0);
    do_write(2*16 + COFS, 32'h0);
    do_write(60, 32'hFFFFFFFF);
    check_counters("R6 counter write ignored");
    check_outs("R6 unmapped write ignored");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule